// File: doc/BRIEF.md
# Programmable Unipolar Magnetic Switch Decision Core

This block is the digital decision stage of a two-wire unipolar magnetic switch. Every clock cycle it takes one signed, already digitized field sample in units of 1 G, with positive values meaning south polarity, and decides which of two supply-current levels the sensor should draw. The operate threshold is an initial offset plus a 6-bit trim code times a fixed step. The release threshold sits a fixed hysteresis below it. The analog front end, chopper and current sinks are outside this block; it only produces the one-bit level request.

A static polarity input picks which field region gives the high current level. In normal polarity a strong south field drives the low level. In reversed polarity it drives the high level. After reset the output always requests the high current level, whichever polarity is selected. Between the two thresholds the previous decision is kept. A threshold that is exactly equal to the sample never causes a change.

Top module: `magsw_core`

## Requirements
- R1: While reset is low and on the first cycle after it is released, current_hi_o is 1 (high current level), for both values of invert_i; it keeps that value until a sample leaves the band between the thresholds.
- R2: With invert_i = 0, a sample strictly greater than the operate threshold makes current_hi_o 0 after the clock edge that captures the sample.
- R3: With invert_i = 0, a sample strictly less than the release threshold makes current_hi_o 1 after the clock edge that captures the sample.
- R4: A sample that is not above the operate threshold and not below the release threshold leaves current_hi_o unchanged.
- R5: Equality is not a crossing: a sample equal to the operate threshold or equal to the release threshold leaves current_hi_o unchanged.
- R6: With invert_i = 1 the output sense is swapped: a sample above the operate threshold gives current_hi_o = 1, and a sample below the release threshold gives current_hi_o = 0.
- R7: The operate threshold is INIT_OP_G + code * STEP_G and the release threshold is that value minus HYST_G, for every code from 0 to 63 (defaults 0, 3 and 15 G, so code 0 gives 0/-15 and code 63 gives 189/174).
- R8: A trim code presented in a cycle sets the thresholds for samples from the next cycle on; the sample of the same cycle still uses the previous thresholds, and a code change that leaves the held state valid causes no output change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one field sample per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| invert_i | input | 1 | Static polarity select: 0 normal, 1 reversed |
| trim_i | input | TRIM_W (6) | Operate-point trim code, unsigned |
| field_i | input | SAMPLE_W (12) | Signed field sample in 1 G units, positive = south |
| current_hi_o | output | 1 | 1 requests the high supply-current level, 0 the low level |

## Verification
A field sample driven in one cycle shows its effect on current_hi_o right after the next rising edge, since the decision state is the only register between field_i and the output. A trim code needs one extra edge: it is loaded into the threshold registers at the edge where it is presented, and it governs samples captured from the following edge on. The bench drives every input on the falling edge and reads current_hi_o one time unit after each rising edge, so each check lands in the cycle these latencies predict, and the trim-timing scenario deliberately presents a new code together with a sample to show the old thresholds still apply to it.

// File: rtl/magsw_pkg.sv
// Package: shared types of the magnetic switch decision core.
// Assumes nothing beyond being compiled before the modules that import it.
package magsw_pkg;

    // Where a sample lies relative to the two thresholds.
    typedef enum logic [1:0] {
        ZONE_HOLD    = 2'b00,   // inside the band, thresholds included
        ZONE_OPERATE = 2'b01,   // strictly above the operate threshold
        ZONE_RELEASE = 2'b10    // strictly below the release threshold
    } zone_e;

    // Output sense selected by the static polarity input.
    typedef enum logic {
        POL_NORMAL   = 1'b0,
        POL_REVERSED = 1'b1
    } polarity_e;

endpackage

// File: rtl/magsw_thresholds.sv
// Module: magsw_thresholds
// Turns the trim code into registered operate and release thresholds.
// Assumes: thresholds fit in THR_W signed bits for every code; HYST_G > 0.
// The registers load on every edge, reset included, so a new code governs
// samples captured from the following edge on.
module magsw_thresholds #(
    parameter int TRIM_W  = 6,
    parameter int THR_W   = 14,
    parameter int INIT_OP = 0,
    parameter int STEP_G  = 3,
    parameter int HYST_G  = 15
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [TRIM_W-1:0]        trim_i,
    output logic signed [THR_W-1:0]  op_thr_o,
    output logic signed [THR_W-1:0]  rel_thr_o
);

    int op_int;
    int rel_int;
    logic signed [THR_W-1:0] op_q;
    logic signed [THR_W-1:0] rel_q;

    // Purpose: arithmetic value of both thresholds for the presented code.
    always_comb begin
        op_int  = INIT_OP + int'(trim_i) * STEP_G;
        rel_int = INIT_OP - HYST_G + int'(trim_i) * STEP_G;
    end

    // Purpose: capture the thresholds for use by the next sample.
    always_ff @(posedge clk) begin
        op_q  <= THR_W'(op_int);
        rel_q <= THR_W'(rel_int);
    end

    assign op_thr_o  = op_q;
    assign rel_thr_o = rel_q;

    // R7
    thr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q - rel_q) == THR_W'(HYST_G))
        else $error("threshold gap differs from hysteresis");

endmodule

// File: rtl/magsw_zone.sv
// Module: magsw_zone
// Classifies one field sample against the operate and release thresholds.
// Assumes: operate threshold above release threshold; strict comparisons,
// so a sample equal to either threshold falls in the hold band.
module magsw_zone
    import magsw_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int THR_W    = 14
) (
    input  logic signed [SAMPLE_W-1:0] field_i,
    input  logic signed [THR_W-1:0]    op_thr_i,
    input  logic signed [THR_W-1:0]    rel_thr_i,
    output zone_e                      zone_o
);

    logic signed [THR_W-1:0] field_x;

    // Purpose: sign-extend the sample to threshold width.
    always_comb field_x = THR_W'(field_i);

    // Purpose: strict comparison, operate crossing checked first.
    always_comb begin
        if (field_x > op_thr_i) begin
            zone_o = ZONE_OPERATE;
        end else if (field_x < rel_thr_i) begin
            zone_o = ZONE_RELEASE;
        end else begin
            zone_o = ZONE_HOLD;
        end
    end

endmodule

// File: rtl/magsw_state.sv
// Module: magsw_state
// Holds the operated/released state and maps it to the current level.
// Assumes: invert_i is static; reset loads the state that yields the
// high current level for the selected polarity.
module magsw_state
    import magsw_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  invert_i,
    input  zone_e zone_i,
    output logic  current_hi_o
);

    logic operated_q;
    polarity_e pol_q;

    // Purpose: hysteresis state; reset picks the high-current state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q      <= polarity_e'(invert_i);
            operated_q <= invert_i;
        end else begin
            pol_q <= polarity_e'(invert_i);
            case (zone_i)
                ZONE_OPERATE: operated_q <= 1'b1;
                ZONE_RELEASE: operated_q <= 1'b0;
                default:      operated_q <= operated_q;
            endcase
        end
    end

    // Purpose: normal polarity draws high current while released.
    always_comb begin
        if (pol_q == POL_REVERSED) begin
            current_hi_o = operated_q;
        end else begin
            current_hi_o = ~operated_q;
        end
    end

    // R1
    powerup_chk: assert property (@(posedge clk)
        !rst_n |=> current_hi_o)
        else $error("output not high after reset");

    // R2
    operate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zone_i == ZONE_OPERATE) |=> operated_q)
        else $error("operate crossing not taken");

    // R3
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zone_i == ZONE_RELEASE) |=> !operated_q)
        else $error("release crossing not taken");

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zone_i == ZONE_HOLD) |=> $stable(operated_q))
        else $error("state changed inside hold band");

endmodule

// File: rtl/magsw_core.sv
// Module: magsw_core (top)
// Decision core of a two-wire unipolar magnetic switch: one signed field
// sample per cycle, registered thresholds from a trim code, hysteresis
// state and polarity mapping to a one-bit current-level request.
// Assumes: samples already in 1 G units; invert_i static during operation.
module magsw_core
    import magsw_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int TRIM_W   = 6,
    parameter int INIT_OP  = 0,
    parameter int STEP_G   = 3,
    parameter int HYST_G   = 15
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       invert_i,
    input  logic [TRIM_W-1:0]          trim_i,
    input  logic signed [SAMPLE_W-1:0] field_i,
    output logic                       current_hi_o
);

    localparam int THR_W = SAMPLE_W + 2;

    logic signed [THR_W-1:0] op_thr;
    logic signed [THR_W-1:0] rel_thr;
    zone_e zone;

    magsw_thresholds #(
        .TRIM_W  (TRIM_W),
        .THR_W   (THR_W),
        .INIT_OP (INIT_OP),
        .STEP_G  (STEP_G),
        .HYST_G  (HYST_G)
    ) u_thresholds (
        .clk       (clk),
        .rst_n     (rst_n),
        .trim_i    (trim_i),
        .op_thr_o  (op_thr),
        .rel_thr_o (rel_thr)
    );

    magsw_zone #(
        .SAMPLE_W (SAMPLE_W),
        .THR_W    (THR_W)
    ) u_zone (
        .field_i   (field_i),
        .op_thr_i  (op_thr),
        .rel_thr_i (rel_thr),
        .zone_o    (zone)
    );

    magsw_state u_state (
        .clk          (clk),
        .rst_n        (rst_n),
        .invert_i     (invert_i),
        .zone_i       (zone),
        .current_hi_o (current_hi_o)
    );

endmodule

// File: tb/magsw_core_bench.sv
// Directed bench for magsw_core with default parameters:
// operate = 3*code G, release = operate - 15 G.
module magsw_core_bench;

    localparam int CLK_PERIOD = 10;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               invert = 1'b0;
    logic [5:0]         trim = 6'd10;
    logic signed [11:0] field = 12'sd20;
    logic               current_hi;

    int n_checks = 0;
    int n_fail   = 0;

    magsw_core u_magsw_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .invert_i     (invert),
        .trim_i       (trim),
        .field_i      (field),
        .current_hi_o (current_hi)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input logic exp, input string req);
        n_checks++;
        if (current_hi !== exp) begin
            n_fail++;
            $display("FAIL %s: current_hi=%b expected %b at %0t", req, current_hi, exp, $time);
        end
    endtask

    // Drive sample and code on the falling edge, read after the next rising edge.
    task automatic step(input int v, input int code, input logic exp, input string req);
        @(negedge clk);
        field = 12'(v);
        trim  = 6'(code);
        @(posedge clk);
        #1;
        check(exp, req);
    endtask

    task automatic do_reset(input logic inv);
        @(negedge clk);
        rst_n  = 1'b0;
        invert = inv;
        field  = 12'sd20;
        trim   = 6'd10;
        repeat (3) @(posedge clk);
        #1;
        check(1'b1, "R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R1: power-up level for both polarities, held inside the band.
    task automatic t_powerup();
        do_reset(1'b0);
        step(20, 10, 1'b1, "R1 normal first cycle");
        step(25, 10, 1'b1, "R1 normal band");
        do_reset(1'b1);
        step(20, 10, 1'b1, "R1 reversed first cycle");
        step(16, 10, 1'b1, "R1 reversed band");
    endtask

    // R2 R3 R4 R5: normal polarity, code 10 (op 30, rel 15).
    task automatic t_normal();
        do_reset(1'b0);
        step(0,  10, 1'b1, "R3 below release");
        step(31, 10, 1'b0, "R2 above operate");
        step(20, 10, 1'b0, "R4 band holds low");
        step(30, 10, 1'b0, "R5 equal operate");
        step(15, 10, 1'b0, "R5 equal release holds low");
        step(14, 10, 1'b1, "R3 below release");
        step(30, 10, 1'b1, "R5 equal operate holds high");
        step(22, 10, 1'b1, "R4 band holds high");
    endtask

    // R6: reversed polarity.
    task automatic t_reversed();
        do_reset(1'b1);
        step(0,  10, 1'b0, "R6 below release low");
        step(31, 10, 1'b1, "R6 above operate high");
        step(16, 10, 1'b1, "R6 band holds high");
        step(15, 10, 1'b1, "R6 equal release holds");
        step(14, 10, 1'b0, "R6 below release low");
        step(30, 10, 1'b0, "R6 equal operate holds");
    endtask

    // R7: both ends of the code range.
    task automatic t_bounds();
        do_reset(1'b0);
        step(-100, 0, 1'b1, "R7 load code 0");
        step(1,    0, 1'b0, "R7 code 0 op=0");
        step(0,    0, 1'b0, "R7 code 0 equal op");
        step(-15,  0, 1'b0, "R7 code 0 equal rel");
        step(-16,  0, 1'b1, "R7 code 0 rel=-15");
        step(-16, 63, 1'b1, "R7 load code 63");
        step(189, 63, 1'b1, "R7 code 63 equal op");
        step(190, 63, 1'b0, "R7 code 63 op=189");
        step(174, 63, 1'b0, "R7 code 63 equal rel");
        step(173, 63, 1'b1, "R7 code 63 rel=174");
    endtask

    // R8: one-cycle trim latency and glitch-free code change.
    task automatic t_trim_timing();
        do_reset(1'b0);
        step(0, 10, 1'b1, "R8 settle code 10");
        step(5,  0, 1'b1, "R8 same-cycle sample uses old op");
        step(5,  0, 1'b0, "R8 next sample uses new op");
        step(5,  1, 1'b0, "R8 change to code 1 keeps low");
        step(5,  1, 1'b0, "R8 code 1 still low");
        step(3,  1, 1'b0, "R8 code 1 equal op holds");
        step(-13, 1, 1'b1, "R8 code 1 rel=-12");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_powerup();
        t_normal();
        t_reversed();
        t_bounds();
        t_trim_timing();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule